// File: doc/BRIEF.md
# Steering Target Resolver

The resolver turns a register offset into the group and instance IDs that send a read of a replicated register to a copy that is present and powered. A replicated register exists once per hardware unit, and a read that reaches a missing unit returns nothing useful. The block holds one address window table for each steering class. It finds the class that owns the offset, then works out the target from availability masks built from fuse and enable inputs.

A request is one cycle with `req_valid` high. The offset, the masks and the default IDs are sampled at the same edge. One cycle later `rsp_valid` is high for one cycle. The hit flag, class index, group and instance are then held until the next request. A small two-state machine carries this. `ST_IDLE` waits for a request. The `req_seen` transition moves it to `ST_RESP` when `req_valid` is high. `ST_RESP` presents the result. From there it stays in `ST_RESP` on a back-to-back request (`req_again`), or goes back to `ST_IDLE` when no request follows (`req_gone`). The window tables are elaboration parameters, and the bus access itself is left to the requester.

Top module: `steer_target_resolver`

## Requirements
- R1: A class owns an offset when lo <= offset <= hi for any of its windows, with both bounds inclusive. Offsets one below lo or one above hi are not owned by that window.
- R2: When more than one class owns an offset, the lowest class index wins. The class indices are 0 for L3 bank, 1 for memory slice, 2 for cache node and 3 for core cluster.
- R3: When no class owns the offset, the response has rsp_hit = 0, rsp_class = 0, and the group and instance equal the default IDs sampled with the request.
- R4: For class 0, group is 0 and instance is the index of the lowest set bit of the bank mask. Bit i of the 3-bit bank fuse enables banks 2i and 2i+1.
- R5: For class 1, group is the index of the lowest available memory slice and instance is 0. Slice m is available when memcache_en[m] is set, or when any of cluster_en[8m+7:8m] is set.
- R6: For class 2, group is twice the index of the lowest available memory slice and instance is 0.
- R7: For class 3, take the index k of the lowest set bit of cluster_en. Group is k / 4 and instance is k % 4.
- R8: When the mask that a class uses is all zero, its derived index is taken as 0.
- R9: rsp_valid is high in exactly the cycle after each request cycle and low otherwise. Back-to-back requests give back-to-back responses in the same order.
- R10: Without a request, rsp_hit, rsp_class, rsp_group and rsp_inst hold their values even when the inputs change. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_offset | input | 24 | Register offset to resolve |
| bank_fuse | input | 3 | Bank-pair enable fuse field |
| memcache_en | input | 4 | Per-memory-slice cache enable |
| cluster_en | input | 32 | Per-core-cluster enable |
| dflt_group | input | 6 | Group ID used on a miss |
| dflt_inst | input | 6 | Instance ID used on a miss |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_hit | output | 1 | An address window matched |
| rsp_class | output | 2 | Winning class index |
| rsp_group | output | 6 | Steering group ID |
| rsp_inst | output | 6 | Steering instance ID |

## Verification
Every result is due exactly one clock edge after its request, because one register stage lies between the inputs and the outputs. The driver pushes the expected tuple on the falling edge where it raises `req_valid`. The monitor pops one entry on each later falling edge that shows `rsp_valid`, so in back-to-back traffic each answer is matched to the request issued one cycle earlier. The hold checks sample two falling edges after the inputs change with no strobe, by which time any wrongly captured value would already be visible.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int OFS_W  = 24;
    localparam int NCLASS = 4;
    localparam int CLS_W  = $clog2(NCLASS);

    // Priority order: lower value wins when windows overlap.
    typedef enum logic [CLS_W-1:0] {
        CLS_BANK    = 2'd0,
        CLS_MSLICE  = 2'd1,
        CLS_NODE    = 2'd2,
        CLS_CLUSTER = 2'd3
    } steer_class_e;

    typedef struct packed {
        logic [OFS_W-1:0] lo;
        logic [OFS_W-1:0] hi;
    } span_t;

endpackage

// File: rtl/steer_span_match.sv
module steer_span_match #(
    parameter int NCLS  = 4,
    parameter int NSPAN = 2,
    parameter steer_pkg::span_t [NCLS*NSPAN-1:0] TBL = '0
) (
    input  logic [steer_pkg::OFS_W-1:0] ofs,
    output logic [NCLS-1:0]             cls_hit
);

    logic [NCLS*NSPAN-1:0] span_hit;

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            for (genvar s = 0; s < NSPAN; s++) begin : g_span
                assign span_hit[c*NSPAN+s] = (ofs >= TBL[c*NSPAN+s].lo) &&
                                             (ofs <= TBL[c*NSPAN+s].hi);
            end
            assign cls_hit[c] = |span_hit[c*NSPAN +: NSPAN];
        end
    endgenerate

endmodule

// File: rtl/steer_lowbit.sv
module steer_lowbit #(
    parameter  int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);

    // Scan from the top so the last assignment is the lowest set bit.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/steer_avail.sv
module steer_avail #(
    parameter  int FUSE_W    = 3,
    parameter  int NMS       = 4,
    parameter  int CL_PER_MS = 8,
    localparam int NCL       = NMS * CL_PER_MS,
    localparam int NBANK     = 2 * FUSE_W
) (
    input  logic [FUSE_W-1:0] bank_fuse,
    input  logic [NMS-1:0]    memcache_en,
    input  logic [NCL-1:0]    cluster_en,
    output logic [NBANK-1:0]  bank_mask,
    output logic [NMS-1:0]    mslice_mask
);

    generate
        // One fuse bit covers a pair of banks.
        for (genvar i = 0; i < FUSE_W; i++) begin : g_bank
            assign bank_mask[2*i +: 2] = {2{bank_fuse[i]}};
        end
        // A slice lives if its cache or any of its clusters lives.
        for (genvar m = 0; m < NMS; m++) begin : g_ms
            assign mslice_mask[m] = memcache_en[m] | (|cluster_en[m*CL_PER_MS +: CL_PER_MS]);
        end
    endgenerate

endmodule

// File: rtl/steer_target_resolver.sv
module steer_target_resolver
    import steer_pkg::*;
#(
    parameter  int FUSE_W        = 3,
    parameter  int NMSLICE       = 4,
    parameter  int CL_PER_MSLICE = 8,
    parameter  int CL_PER_GROUP  = 4,
    parameter  int ID_W          = 6,
    parameter  int NSPAN         = 2,
    parameter  span_t [NCLASS*NSPAN-1:0] SPAN_TBL = {
        {24'h00B200, 24'h00B2FF},   // cluster, window 1
        {24'h005200, 24'h0052FF},   // cluster, window 0
        {24'h00D800, 24'h00D8FF},   // node, window 1
        {24'h00B000, 24'h00B0FF},   // node, window 0
        {24'h00E900, 24'h00FFFF},   // memory slice, window 1
        {24'h00DD00, 24'h00DDFF},   // memory slice, window 0
        {24'h024000, 24'h0240FF},   // bank, window 1
        {24'h00B100, 24'h00B3FF}    // bank, window 0
    },
    localparam int NCLUSTER = NMSLICE * CL_PER_MSLICE,
    localparam int NBANK    = 2 * FUSE_W,
    localparam int BANK_IW  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int MS_IW    = (NMSLICE > 1) ? $clog2(NMSLICE) : 1,
    localparam int CL_IW    = (NCLUSTER > 1) ? $clog2(NCLUSTER) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [FUSE_W-1:0]  bank_fuse,
    input  logic [NMSLICE-1:0] memcache_en,
    input  logic [NCLUSTER-1:0] cluster_en,
    input  logic [ID_W-1:0]    dflt_group,
    input  logic [ID_W-1:0]    dflt_inst,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [CLS_W-1:0]   rsp_class,
    output logic [ID_W-1:0]    rsp_group,
    output logic [ID_W-1:0]    rsp_inst
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;

    st_e state_q, state_d;

    logic [NCLASS-1:0]  cls_hit;
    logic [CLS_W-1:0]   win_cls;
    logic               any_hit;
    logic [NBANK-1:0]   bank_mask;
    logic [NMSLICE-1:0] mslice_mask;
    logic [BANK_IW-1:0] bank_idx;
    logic [MS_IW-1:0]   ms_idx;
    logic [CL_IW-1:0]   cl_idx;
    logic               bank_any, ms_any, cl_any;

    logic               nxt_hit;
    logic [CLS_W-1:0]   nxt_class;
    logic [ID_W-1:0]    nxt_group;
    logic [ID_W-1:0]    nxt_inst;

    steer_span_match #(
        .NCLS  (NCLASS),
        .NSPAN (NSPAN),
        .TBL   (SPAN_TBL)
    ) u_match (
        .ofs     (req_offset),
        .cls_hit (cls_hit)
    );

    steer_lowbit #(.W(NCLASS)) u_pick_cls (
        .vec   (cls_hit),
        .idx   (win_cls),
        .found (any_hit)
    );

    steer_avail #(
        .FUSE_W    (FUSE_W),
        .NMS       (NMSLICE),
        .CL_PER_MS (CL_PER_MSLICE)
    ) u_avail (
        .bank_fuse   (bank_fuse),
        .memcache_en (memcache_en),
        .cluster_en  (cluster_en),
        .bank_mask   (bank_mask),
        .mslice_mask (mslice_mask)
    );

    steer_lowbit #(.W(NBANK)) u_pick_bank (
        .vec   (bank_mask),
        .idx   (bank_idx),
        .found (bank_any)
    );

    steer_lowbit #(.W(NMSLICE)) u_pick_ms (
        .vec   (mslice_mask),
        .idx   (ms_idx),
        .found (ms_any)
    );

    steer_lowbit #(.W(NCLUSTER)) u_pick_cl (
        .vec   (cluster_en),
        .idx   (cl_idx),
        .found (cl_any)
    );

    // Target derivation; an empty mask leaves the index at zero.
    always_comb begin
        nxt_hit   = any_hit;
        nxt_class = '0;
        nxt_group = dflt_group;
        nxt_inst  = dflt_inst;
        if (any_hit) begin
            nxt_class = win_cls;
            unique case (steer_class_e'(win_cls))
                CLS_BANK: begin
                    nxt_group = '0;
                    nxt_inst  = bank_any ? ID_W'(bank_idx) : '0;
                end
                CLS_MSLICE: begin
                    nxt_group = ms_any ? ID_W'(ms_idx) : '0;
                    nxt_inst  = '0;
                end
                CLS_NODE: begin
                    nxt_group = ms_any ? ID_W'({ms_idx, 1'b0}) : '0;
                    nxt_inst  = '0;
                end
                CLS_CLUSTER: begin
                    nxt_group = cl_any ? ID_W'(cl_idx / CL_IW'(CL_PER_GROUP)) : '0;
                    nxt_inst  = cl_any ? ID_W'(cl_idx % CL_IW'(CL_PER_GROUP)) : '0;
                end
                default: begin
                    nxt_group = '0;
                    nxt_inst  = '0;
                end
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;   // req_seen
            ST_RESP: if (!req_valid) state_d = ST_IDLE;   // req_gone, else req_again
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers, loaded only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_class <= '0;
            rsp_group <= '0;
            rsp_inst  <= '0;
        end else if (req_valid) begin
            rsp_hit   <= nxt_hit;
            rsp_class <= nxt_class;
            rsp_group <= nxt_group;
            rsp_inst  <= nxt_inst;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/steer_target_checker.sv
module steer_target_checker #(
    parameter int ID_W         = 6,
    parameter int CL_PER_GROUP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [ID_W-1:0] dflt_group,
    input logic [ID_W-1:0] dflt_inst,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [1:0]      rsp_class,
    input logic [ID_W-1:0] rsp_group,
    input logic [ID_W-1:0] rsp_inst
);

    // R9
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    hold_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_group) && $stable(rsp_inst) && $stable(rsp_hit) && $stable(rsp_class)));

    // R3
    miss_uses_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_class == 2'd0 && rsp_group == $past(dflt_group) && rsp_inst == $past(dflt_inst)));

    // R4
    bank_group_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_class == 2'd0) |-> (rsp_group == '0));

    // R5
    mslice_inst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_class == 2'd1) |-> (rsp_inst == '0));

    // R6
    node_group_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_class == 2'd2) |-> (rsp_group[0] == 1'b0 && rsp_inst == '0));

    // R7
    cluster_inst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_class == 2'd3) |-> (rsp_inst < ID_W'(CL_PER_GROUP)));

endmodule

bind steer_target_resolver steer_target_checker #(
    .ID_W         (ID_W),
    .CL_PER_GROUP (CL_PER_GROUP)
) u_chk (.*);

// File: tb/tb_steer_target_resolver.sv
module tb_steer_target_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_offset = '0;
    logic [2:0]  bank_fuse = '0;
    logic [3:0]  memcache_en = '0;
    logic [31:0] cluster_en = '0;
    logic [5:0]  dflt_group = '0;
    logic [5:0]  dflt_inst = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_class;
    logic [5:0]  rsp_group;
    logic [5:0]  rsp_inst;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        hit;
        logic [1:0]  cls;
        logic [5:0]  grp;
        logic [5:0]  ins;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #10 clk = ~clk;   // 50 MHz

    steer_target_resolver dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_offset  (req_offset),
        .bank_fuse   (bank_fuse),
        .memcache_en (memcache_en),
        .cluster_en  (cluster_en),
        .dflt_group  (dflt_group),
        .dflt_inst   (dflt_inst),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_class   (rsp_class),
        .rsp_group   (rsp_group),
        .rsp_inst    (rsp_inst)
    );

    // Monitor: each response is compared with the oldest pending request.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 response with no request: act valid=1 exp valid=0");
            end else begin
                cur = exp_q.pop_front();
                if ({rsp_hit, rsp_class, rsp_group, rsp_inst} !== {cur.hit, cur.cls, cur.grp, cur.ins}) begin
                    errors++;
                    $display("FAIL %s act hit=%0d cls=%0d grp=%0d ins=%0d exp hit=%0d cls=%0d grp=%0d ins=%0d",
                             cur.tag, rsp_hit, rsp_class, rsp_group, rsp_inst,
                             cur.hit, cur.cls, cur.grp, cur.ins);
                end
            end
        end
    end

    task automatic send(input logic [23:0] ofs, input logic [2:0] fz, input logic [3:0] mc,
                        input logic [31:0] ce, input logic [5:0] dg, input logic [5:0] di,
                        input logic eh, input logic [1:0] ec, input logic [5:0] eg,
                        input logic [5:0] ei, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid   = 1'b1;
        req_offset  = ofs;
        bank_fuse   = fz;
        memcache_en = mc;
        cluster_en  = ce;
        dflt_group  = dg;
        dflt_inst   = di;
        e.hit = eh; e.cls = ec; e.grp = eg; e.ins = ei; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    initial begin
        logic [5:0] held_g, held_i;
        logic       held_h;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(rsp_valid == 1'b0, "R10 reset valid", rsp_valid, 0);
        chk({rsp_hit, rsp_class, rsp_group, rsp_inst} == '0, "R10 reset outputs",
            {rsp_hit, rsp_class, rsp_group, rsp_inst}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 idle after reset", rsp_valid, 0);

        // Masks: fuse 110 -> banks 2..5; cluster 13 only -> slice 1, group 3 inst 1.
        send(24'h00B100, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd0, 6'd0, 6'd2, "R1 R4 bank window lo");
        send(24'h00B3FF, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd0, 6'd0, 6'd2, "R1 bank window hi");
        send(24'h00B200, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd0, 6'd0, 6'd2, "R2 bank beats cluster");
        send(24'h00B0FF, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd2, 6'd2, 6'd0, "R1 R6 below bank lo");
        send(24'h00B400, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b0, 2'd0, 6'd5, 6'd3, "R1 R3 above bank hi");
        send(24'h00DD80, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd1, 6'd1, 6'd0, "R5 slice from cluster");
        send(24'h005210, 3'b110, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd3, 6'd3, 6'd1, "R7 cluster 13");
        send(24'h024000, 3'b100, 4'b0000, 32'h0000_2000, 6'd5, 6'd3, 1'b1, 2'd0, 6'd0, 6'd4, "R1 R4 second window fuse 100");
        // Slice availability from cache enable only; no clusters.
        send(24'h00E900, 3'b110, 4'b0100, 32'h0000_0000, 6'd5, 6'd3, 1'b1, 2'd1, 6'd2, 6'd0, "R5 slice from cache");
        send(24'h00D800, 3'b110, 4'b0100, 32'h0000_0000, 6'd5, 6'd3, 1'b1, 2'd2, 6'd4, 6'd0, "R6 node slice 2");
        send(24'h0052FF, 3'b110, 4'b0100, 32'h0000_0000, 6'd5, 6'd3, 1'b1, 2'd3, 6'd0, 6'd0, "R8 empty cluster mask");
        send(24'h00B1FF, 3'b000, 4'b0100, 32'h0000_0000, 6'd5, 6'd3, 1'b1, 2'd0, 6'd0, 6'd0, "R8 empty bank mask");
        send(24'h00DDFF, 3'b110, 4'b0000, 32'h0000_0000, 6'd5, 6'd3, 1'b1, 2'd1, 6'd0, 6'd0, "R8 empty slice mask");
        // Only top cluster alive.
        send(24'h005200, 3'b001, 4'b0000, 32'h8000_0000, 6'd5, 6'd3, 1'b1, 2'd3, 6'd7, 6'd3, "R7 cluster 31");
        send(24'h00FFFF, 3'b001, 4'b0000, 32'h8000_0000, 6'd5, 6'd3, 1'b1, 2'd1, 6'd3, 6'd0, "R5 slice 3 window hi");
        send(24'h00D8FF, 3'b001, 4'b0000, 32'h8000_0000, 6'd5, 6'd3, 1'b1, 2'd2, 6'd6, 6'd0, "R6 node slice 3");
        send(24'h000000, 3'b001, 4'b0000, 32'h8000_0000, 6'h2A, 6'h15, 1'b0, 2'd0, 6'h2A, 6'h15, "R3 miss at zero");
        idle();
        held_h = rsp_hit; held_g = rsp_group; held_i = rsp_inst;
        // R10 hold: change inputs with no strobe.
        req_offset = 24'h005200; cluster_en = 32'h1; dflt_group = 6'd9; dflt_inst = 6'd9;
        idle();
        idle();
        chk(rsp_valid == 1'b0, "R9 no response without request", rsp_valid, 0);
        chk(rsp_hit == held_h && rsp_group == held_g && rsp_inst == held_i, "R10 hold group",
            rsp_group, held_g);
        chk(exp_q.size() == 0, "R9 every request answered", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule